// File: doc/BRIEF.md
# UART Receive/Transmit Buffer with Trigger Interrupts

This block is the buffering and interrupt core of a byte-oriented serial port. A deserialiser hands it received bytes, a serialiser drains transmit bytes from it, and a CPU sees it through a small byte-wide register window. Four registers are exposed: a data port, an interrupt enable register, a shared identification/FIFO-control location, and a line status register. Reads take effect combinationally on `regRdata`, and any side effects of a read occur at the clock edge on which `regRd` is high.

Received bytes collect in a 16-entry queue. An interrupt is raised once the queue holds at least a programmable number of bytes, chosen from four fixed levels. Transmit bytes queue the same way and leave in order whenever the serialiser is ready. A pending event is raised when the transmit queue drains. The highest-priority pending source is reported as a 3-bit code. Bit-level shifting, baud timing and modem lines sit outside this block.

Top module: `uart_buf_irq`

## Requirements
- R1: After reset the identification location reads 0x01, line status reads 0x20, `irqOut` is 0 and `txValid` is 0.
- R2: Register address 0 is the data port. Reading it returns the oldest received byte and removes that byte. Received bytes come out in arrival order. Line status bit 0 is 1 exactly while the receive queue is non-empty.
- R3: Writing address 0 queues a transmit byte. `txValid` is high while the transmit queue is non-empty, with `txByte` showing the oldest byte. Each cycle with `txValid` and `txReady` both high consumes one byte, and bytes leave in write order.
- R4: With FIFOs enabled, each queue holds 16 bytes. A data write to a full transmit queue is discarded. Line status bit 5 is 1 exactly while the transmit queue is not full.
- R5: A received byte that arrives at a full receive queue is discarded and sets line status bit 1. That bit stays set until line status (address 3) is read; the read itself still returns it as 1.
- R6: A write to address 2 sets the FIFO control: bits [7:6] pick a receive threshold of 1, 4, 8 or 14 bytes for codes 0 to 3. The receive-data interrupt is pending exactly while the queue holds at least that many bytes.
- R7: In a write to address 2, bit 1 empties the receive queue and bit 2 empties the transmit queue, once. These bits are not stored: a later control write without them leaves the queues untouched.
- R8: Control bit 0 enables the FIFOs. While it is 0, each queue holds a single byte and the receive threshold is 1 regardless of bits [7:6].
- R9: Address 1 holds the enables: bit 0 receive data, bit 1 transmit empty, bit 2 line status (overrun). `irqOut` is 1 exactly when some enabled source is pending; a disabled source never raises it.
- R10: Reading address 2 returns {4'b0, code, n}. n is 0 when an enabled source is pending and 1 otherwise. code is 3 for line status, 2 for receive data and 1 for transmit empty; line status has the highest priority and transmit empty the lowest. With nothing pending the read returns 0x01, with line status pending 0x06, with receive data pending 0x04, and with transmit empty pending 0x02.
- R11: The transmit-empty event is set at reset, when the transmit queue drains to empty, and when it is cleared by control bit 2. It is cleared by a transmit data write or by an identification read that reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects at the edge) |
| regAddr | input | 2 | Register address: 0 data, 1 enable, 2 identification/control, 3 status |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| rxValid | input | 1 | Deserialiser presents a received byte this cycle |
| rxByte | input | 8 | Received byte |
| txReady | input | 1 | Serialiser can take a byte this cycle |
| txValid | output | 1 | A transmit byte is available |
| txByte | output | 8 | Oldest transmit byte |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench checks each threshold one byte below and at its level. It also drains a queue below the level. A design with a wrong threshold table, or an off-by-one compare, would raise the interrupt a byte early or late. Both queues are filled to exactly 16 and then pushed once more. A faulty full test would overwrite the oldest byte, or fail to flag overrun, which would show up in the drained order or in status bit 1. Other cases cover a pending overrun beside pending receive data, to catch inverted priority. They cover the transmit-empty event being cleared by an identification read and re-armed by draining. They show that a one-shot queue clear does not repeat on a later control write, and that with FIFOs disabled the depth is one and the threshold is one.

// File: rtl/ubuf_pkg.sv
package ubuf_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_ID   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam logic [2:0] CODE_THRE = 3'd1;
  localparam logic [2:0] CODE_RXDA = 3'd2;
  localparam logic [2:0] CODE_LINE = 3'd3;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic rxClr;
    logic txPush;
    logic txPop;
    logic txClr;
  } ubufStrobes_t;
endpackage

// File: rtl/ubuf_fifo.sv
module ubuf_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rdPtr];

  assert_push_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> (count < CW'(DEPTH)));
  assert_pop_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> (count != '0));
endmodule

// File: rtl/ubuf_datapath.sv
module ubuf_datapath
  import ubuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ubufStrobes_t str,
  input  logic [7:0]   rxByte,
  input  logic [7:0]   txData,
  output logic [7:0]   rxHead,
  output logic [7:0]   txHead,
  output logic [CW-1:0] rxCount,
  output logic [CW-1:0] txCount
);
  ubuf_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(str.rxPush), .pop(str.rxPop), .clr(str.rxClr),
    .din(rxByte), .dout(rxHead), .count(rxCount)
  );

  ubuf_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(str.txPush), .pop(str.txPop), .clr(str.txClr),
    .din(txData), .dout(txHead), .count(txCount)
  );
endmodule

// File: rtl/ubuf_ctrl.sv
module ubuf_ctrl
  import ubuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [1:0]    regAddr,
  input  logic [7:0]    regWdata,
  output logic [7:0]    regRdata,
  input  logic          rxValid,
  input  logic          txReady,
  output logic          txValid,
  output logic          irqOut,
  input  logic [7:0]    rxHead,
  input  logic [CW-1:0] rxCount,
  input  logic [CW-1:0] txCount,
  output ubufStrobes_t  str
);
  logic       fifoEn;
  logic [1:0] trigSel;
  logic [2:0] ieReg;
  logic       overrun;
  logic       thrPend;

  logic [CW-1:0] cap, thr;
  logic rxFull, txFull, rxNonEmpty;
  logic wrData, rdData, wrCtl, rdId, wrEn, rdStat;
  logic lsPend, rdPend, thPend;
  logic [2:0] idCode;
  logic [7:0] idVal, statVal;

  assign wrData = regWr && (regAddr == ADDR_DATA);
  assign rdData = regRd && (regAddr == ADDR_DATA);
  assign wrEn   = regWr && (regAddr == ADDR_EN);
  assign wrCtl  = regWr && (regAddr == ADDR_ID);
  assign rdId   = regRd && (regAddr == ADDR_ID);
  assign rdStat = regRd && (regAddr == ADDR_STAT);

  assign cap        = fifoEn ? CW'(DEPTH) : CW'(1);
  assign rxFull     = (rxCount >= cap);
  assign txFull     = (txCount >= cap);
  assign rxNonEmpty = (rxCount != '0);

  always_comb begin
    if (!fifoEn) thr = CW'(1);
    else begin
      case (trigSel)
        2'd0:    thr = CW'(1);
        2'd1:    thr = CW'(4);
        2'd2:    thr = CW'(8);
        default: thr = CW'(14);
      endcase
    end
  end

  always_comb begin
    str        = '0;
    str.rxPush = rxValid && !rxFull;
    str.rxPop  = rdData && rxNonEmpty;
    str.rxClr  = wrCtl && regWdata[1];
    str.txPush = wrData && !txFull;
    str.txPop  = txReady && (txCount != '0);
    str.txClr  = wrCtl && regWdata[2];
  end

  assign lsPend = ieReg[2] && overrun;
  assign rdPend = ieReg[0] && rxNonEmpty && (rxCount >= thr);
  assign thPend = ieReg[1] && thrPend;

  always_comb begin
    if (lsPend)      idCode = CODE_LINE;
    else if (rdPend) idCode = CODE_RXDA;
    else if (thPend) idCode = CODE_THRE;
    else             idCode = CODE_NONE;
  end

  assign idVal   = {4'b0000, idCode, (idCode == CODE_NONE)};
  assign statVal = {2'b00, !txFull, 3'b000, overrun, rxNonEmpty};
  assign irqOut  = lsPend || rdPend || thPend;
  assign txValid = (txCount != '0);

  always_comb begin
    case (regAddr)
      ADDR_DATA: regRdata = rxNonEmpty ? rxHead : 8'h00;
      ADDR_EN:   regRdata = {5'b00000, ieReg};
      ADDR_ID:   regRdata = idVal;
      default:   regRdata = statVal;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifoEn  <= 1'b0;
      trigSel <= 2'd0;
      ieReg   <= 3'd0;
      overrun <= 1'b0;
      thrPend <= 1'b1;
    end else begin
      if (wrCtl) begin
        fifoEn  <= regWdata[0];
        trigSel <= regWdata[7:6];
      end
      if (wrEn) ieReg <= regWdata[2:0];

      if (rxValid && rxFull && !str.rxClr) overrun <= 1'b1;
      else if (rdStat)                     overrun <= 1'b0;

      if (str.txClr || (str.txPop && txCount == CW'(1) && !str.txPush))
        thrPend <= 1'b1;
      else if (str.txPush || (rdId && idCode == CODE_THRE))
        thrPend <= 1'b0;
    end
  end

  assert_overrun_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !rdStat) |=> overrun);
  assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    str.rxClr |=> (rxCount == '0));
  assert_drain_arms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txValid) |-> thrPend);
  assert_trigger_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ieReg[0] && rxCount >= thr && rxCount != '0) |-> irqOut);
endmodule

// File: rtl/uart_buf_irq.sv
module uart_buf_irq
  import ubuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReady,
  output logic       txValid,
  output logic [7:0] txByte,
  output logic       irqOut
);
  ubufStrobes_t str;
  logic [7:0]    rxHead;
  logic [CW-1:0] rxCount, txCount;

  ubuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rxValid(rxValid), .txReady(txReady),
    .txValid(txValid), .irqOut(irqOut), .rxHead(rxHead),
    .rxCount(rxCount), .txCount(txCount), .str(str)
  );

  ubuf_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .str(str),
    .rxByte(rxByte), .txData(regWdata),
    .rxHead(rxHead), .txHead(txByte),
    .rxCount(rxCount), .txCount(txCount)
  );
endmodule

// File: tb/uart_buf_irq_bench.sv
module uart_buf_irq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic txReady = 1'b0;
  logic txValid;
  logic [7:0] txByte;
  logic irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] txExpQ[$];

  always #4 clk = ~clk;

  uart_buf_irq u_uart_buf_irq (
    .clk(clk), .rst_n(rst_n), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .rxValid(rxValid), .rxByte(rxByte), .txReady(txReady),
    .txValid(txValid), .txByte(txByte), .irqOut(irqOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 v = regRdata;
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b;
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic txSend(input logic [7:0] b);
    txExpQ.push_back(b);
    wr(2'd0, b);
  endtask

  task automatic drainTx();
    @(negedge clk); txReady = 1'b1;
    while (txValid) @(negedge clk);
    @(negedge clk); txReady = 1'b0;
    #1 check("R3 queue empty after drain", txExpQ.size(), 0);
  endtask

  // monitor: compares every consumed transmit byte against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && txValid && txReady) begin
        if (txExpQ.size() == 0) check("R3 unexpected tx byte", txByte, 256);
        else check("R3 tx order", txByte, txExpQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 irq at reset", irqOut, 0);
    check("R1 txValid at reset", txValid, 0);
    rdCheck("R1 id at reset", 2'd2, 8'h01);
    rdCheck("R1 status at reset", 2'd3, 8'h20);

    // R2 / R6 / R9 / R10 basic receive, threshold 1
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h01);
    #1 check("R9 no irq when empty", irqOut, 0);
    rxPush(8'h11);
    check("R6 irq at level 1", irqOut, 1);
    rdCheck("R10 id reports rx data", 2'd2, 8'h04);
    rdCheck("R2 status data ready", 2'd3, 8'h21);
    rxPush(8'h22); rxPush(8'h33);
    rdCheck("R2 order 1", 2'd0, 8'h11);
    rdCheck("R2 order 2", 2'd0, 8'h22);
    rdCheck("R2 order 3", 2'd0, 8'h33);
    check("R6 irq cleared when empty", irqOut, 0);
    rdCheck("R2 status empty", 2'd3, 8'h20);

    // R6 threshold 4
    wr(2'd2, 8'h41);
    for (int i = 0; i < 3; i++) rxPush(8'h40 + 8'(i));
    check("R6 below level 4", irqOut, 0);
    rxPush(8'h43);
    check("R6 at level 4", irqOut, 1);
    rdCheck("R2 level4 first", 2'd0, 8'h40);
    check("R6 drops below level 4", irqOut, 0);
    for (int i = 1; i < 4; i++) rdCheck("R2 level4 rest", 2'd0, 8'h40 + 8'(i));

    // R6 threshold 8
    wr(2'd2, 8'h81);
    for (int i = 0; i < 7; i++) rxPush(8'h80 + 8'(i));
    check("R6 below level 8", irqOut, 0);
    rxPush(8'h87);
    check("R6 at level 8", irqOut, 1);
    for (int i = 0; i < 8; i++) rdCheck("R2 level8 drain", 2'd0, 8'h80 + 8'(i));

    // R6 threshold 14, R4 depth, R5 overrun, R10 priority
    wr(2'd2, 8'hC1);
    for (int i = 0; i < 13; i++) rxPush(8'(i));
    check("R6 below level 14", irqOut, 0);
    rxPush(8'd13);
    check("R6 at level 14", irqOut, 1);
    rxPush(8'd14); rxPush(8'd15);
    rxPush(8'hEE);
    wr(2'd1, 8'h05);
    rdCheck("R10 line status over rx data", 2'd2, 8'h06);
    rdCheck("R5 overrun flagged", 2'd3, 8'h23);
    rdCheck("R5 overrun cleared by read", 2'd3, 8'h21);
    rdCheck("R10 rx data after overrun clear", 2'd2, 8'h04);
    for (int i = 0; i < 16; i++) rdCheck("R5 full rx order", 2'd0, 8'(i));
    rdCheck("R5 dropped byte not stored", 2'd3, 8'h20);

    // R11 transmit empty event, R9 enable
    wr(2'd1, 8'h02);
    #1 check("R11 armed since reset", irqOut, 1);
    rdCheck("R11 id reports tx empty", 2'd2, 8'h02);
    rdCheck("R11 cleared by id read", 2'd2, 8'h01);
    check("R11 irq low after id read", irqOut, 0);

    // R3 / R4 tx fill to 16 then overflow
    for (int i = 0; i < 16; i++) txSend(8'hA0 + 8'(i));
    check("R3 txValid when queued", txValid, 1);
    rdCheck("R4 status tx full", 2'd3, 8'h00);
    wr(2'd0, 8'h5A);
    drainTx();
    #1 check("R11 rearmed after drain", irqOut, 1);
    rdCheck("R4 status tx room", 2'd3, 8'h20);
    wr(2'd1, 8'h00);
    #1 check("R9 disabled source silent", irqOut, 0);

    // R7 one-shot clears
    wr(2'd0, 8'h01); wr(2'd0, 8'h02); wr(2'd0, 8'h03);
    rxPush(8'h61); rxPush(8'h62);
    wr(2'd2, 8'h03);
    rdCheck("R7 rx cleared", 2'd3, 8'h20);
    #1 check("R7 tx untouched by rx clear", txValid, 1);
    wr(2'd2, 8'h05);
    #1 check("R7 tx cleared", txValid, 0);
    wr(2'd1, 8'h02);
    rdCheck("R11 armed by tx clear", 2'd2, 8'h02);
    wr(2'd1, 8'h00);
    rxPush(8'h63);
    wr(2'd2, 8'h01);
    rdCheck("R7 clear not stored", 2'd0, 8'h63);

    // R8 FIFOs disabled: depth 1, threshold 1
    wr(2'd2, 8'hC0);
    rxPush(8'hB1); rxPush(8'hB2);
    rdCheck("R8 second rx byte overruns", 2'd3, 8'h23);
    rdCheck("R8 single rx entry", 2'd0, 8'hB1);
    rdCheck("R8 rx empty after one read", 2'd3, 8'h20);
    wr(2'd1, 8'h01);
    rxPush(8'hB3);
    #1 check("R8 threshold forced to 1", irqOut, 1);
    rdCheck("R8 read back", 2'd0, 8'hB3);
    wr(2'd1, 8'h00);
    txSend(8'hC5);
    rdCheck("R8 tx full at one", 2'd3, 8'h00);
    wr(2'd0, 8'hC6);
    drainTx();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule